// File: doc/BRIEF.md
# Program Status Word Unit with Byte-Masked Updates

This block keeps the processor's live status word together with one saved copy of it for each privileged exception bank. A move-to-status request carries a 32-bit value, a 4-bit byte-enable mask and a target selector. The selector picks either the live word or the saved copy that belongs to the bank of the current mode. A separate port writes a whole saved word for a mode named on the port. A combinational read port returns the saved word for a named mode.

The condition flags, the two interrupt masks and the mode field are broken out as separate outputs. When a live-word update moves the mode field to a new value, a one-cycle strobe tells the surrounding core that it must swap register banks. Doing that swap, and producing flags from arithmetic, is left to other blocks.

Top module: `psr_unit`

## Requirements
- R1: While `rstN` is low, and after it is released until the first write, `statusWord` is 0x000000D3 (supervisor mode, both interrupt masks set), every saved word is zero and `modeChange` is low.
- R2: A move-to-status request to the live word (`msrValid`=1, `msrToSaved`=0) replaces, at the next rising edge, each byte whose enable is set: `msrMask[0]` covers bits 7:0, `msrMask[1]` bits 15:8, `msrMask[2]` bits 23:16 and `msrMask[3]` bits 31:24. Bytes whose enable is clear keep their value.
- R3: While the mode field is user (0b10000), a live-word request updates only bits 31:24 when `msrMask[3]` is set. The enables in `msrMask[2:0]` have no effect, and so the mode cannot be left this way.
- R4: `flagN`, `flagZ`, `flagC` and `flagV` equal status bits 31, 30, 29 and 28. `irqMasked` is bit 7, `fiqMasked` is bit 6, and `modeField` is bits 4:0.
- R5: `modeChange` is high for exactly the one cycle after an edge at which the mode field took a new value. It is low in every other cycle.
- R6: A move-to-status request with `msrToSaved`=1 updates the saved word of the current mode's bank, using the same byte enables as R2. It leaves the live word unchanged.
- R7: Only the fast-interrupt (0b10001), interrupt (0b10010), supervisor (0b10011), abort (0b10111) and undefined (0b11011) modes own a saved word. A saved-target request made in any other mode changes nothing.
- R8: `savedRdData` returns, in the same cycle, the saved word of the bank of `savedRdMode`. If that mode owns no saved word, it returns the live status word.
- R9: A direct write (`savedWrValid`=1) stores the whole of `savedWrData` into the saved word of the bank of `savedWrMode` at the next edge. If that mode owns no saved word, the write is dropped.
- R10: If a saved-target request and a direct write hit the same saved word in one cycle, the request wins and the direct write is dropped. A direct write to a different bank in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msrValid | input | 1 | Move-to-status request |
| msrToSaved | input | 1 | Request targets the saved word of the current bank |
| msrMask | input | 4 | Byte enables for the request |
| msrData | input | 32 | Request value |
| savedWrValid | input | 1 | Direct whole-word saved write |
| savedWrMode | input | 5 | Mode naming the saved word to write |
| savedWrData | input | 32 | Direct write value |
| savedRdMode | input | 5 | Mode naming the saved word to read |
| savedRdData | output | 32 | Saved word, or the live word for modes without one |
| statusWord | output | 32 | Live status word |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| irqMasked | output | 1 | Interrupt mask |
| fiqMasked | output | 1 | Fast-interrupt mask |
| modeField | output | 5 | Current mode |
| modeChange | output | 1 | One-cycle strobe after the mode field changes |

## Verification
The hardest case to reach is a saved-target request and a direct write landing on the same saved word in the same cycle. The saved word is chosen by the current mode, not by the port, so the stimulus must first steer the live mode into a privileged bank and then aim the direct write at that same bank. The bench does this with directed sequences. It then runs long mixed traffic that draws mode values often from the legal set and resets from time to time, because once user mode is entered only a reset leaves it. A behavioural model compares every output, and every saved word is reached by sweeping the read port.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int WORD_W      = 32;
  localparam int BYTE_CNT    = WORD_W / 8;
  localparam int SAVED_BANKS = 5;
  localparam int MODE_W      = 5;

  localparam logic [MODE_W-1:0] MODE_USER  = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ   = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ   = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC   = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT   = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND   = 5'b11011;

  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_00D3;

  typedef struct packed {
    logic [BYTE_CNT-1:0]    liveByteEn;
    logic [BYTE_CNT-1:0]    savedByteEn;
    logic [SAVED_BANKS-1:0] savedSel;
    logic [SAVED_BANKS-1:0] directSel;
  } psrStrobe_t;

  // One-hot bank of a mode; zero when the mode owns no saved word.
  function automatic logic [SAVED_BANKS-1:0] bankOf(input logic [MODE_W-1:0] m);
    logic [SAVED_BANKS-1:0] r;
    case (m)
      MODE_FIQ: r = 5'b00001;
      MODE_IRQ: r = 5'b00010;
      MODE_SVC: r = 5'b00100;
      MODE_ABT: r = 5'b01000;
      MODE_UND: r = 5'b10000;
      default:  r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic                msrValid,
  input  logic                msrToSaved,
  input  logic [BYTE_CNT-1:0] msrMask,
  input  logic                savedWrValid,
  input  logic [MODE_W-1:0]   savedWrMode,
  input  logic [MODE_W-1:0]   curMode,
  output psrStrobe_t          strobe
);
  localparam logic [BYTE_CNT-1:0] TOP_BYTE_ONLY = {1'b1, {(BYTE_CNT-1){1'b0}}};

  logic [SAVED_BANKS-1:0] curBank;
  logic [SAVED_BANKS-1:0] dirBank;
  logic                   inUser;
  logic                   liveReq;
  logic                   savedReq;

  always_comb begin
    curBank  = bankOf(curMode);
    dirBank  = bankOf(savedWrMode);
    inUser   = (curMode == MODE_USER);
    liveReq  = msrValid && !msrToSaved;
    savedReq = msrValid && msrToSaved;

    strobe.liveByteEn  = '0;
    strobe.savedByteEn = '0;
    strobe.savedSel    = '0;
    strobe.directSel   = '0;

    if (liveReq)
      strobe.liveByteEn = inUser ? (msrMask & TOP_BYTE_ONLY) : msrMask;
    if (savedReq) begin
      strobe.savedByteEn = msrMask;
      strobe.savedSel    = curBank;
    end
    if (savedWrValid)
      strobe.directSel = dirBank & ~strobe.savedSel;
  end
endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  psrStrobe_t        strobe,
  input  logic [WORD_W-1:0] msrData,
  input  logic [WORD_W-1:0] savedWrData,
  input  logic [MODE_W-1:0] savedRdMode,
  output logic [WORD_W-1:0] liveWord,
  output logic [WORD_W-1:0] savedRdData,
  output logic              modeChange
);
  logic [WORD_W-1:0] liveNext;
  logic [WORD_W-1:0] savedWord [SAVED_BANKS];
  logic [SAVED_BANKS-1:0] rdSel;

  genvar b, k;
  generate
    for (b = 0; b < BYTE_CNT; b++) begin : g_live
      assign liveNext[b*8 +: 8] = strobe.liveByteEn[b] ? msrData[b*8 +: 8]
                                                       : liveWord[b*8 +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveWord   <= RESET_WORD;
      modeChange <= 1'b0;
    end else begin
      liveWord   <= liveNext;
      modeChange <= (liveNext[MODE_W-1:0] != liveWord[MODE_W-1:0]);
    end
  end

  generate
    for (k = 0; k < SAVED_BANKS; k++) begin : g_bank
      logic [WORD_W-1:0] merged;
      for (b = 0; b < BYTE_CNT; b++) begin : g_byte
        assign merged[b*8 +: 8] = strobe.savedByteEn[b] ? msrData[b*8 +: 8]
                                                        : savedWord[k][b*8 +: 8];
      end
      always_ff @(posedge clk) begin
        if (!rstN)
          savedWord[k] <= '0;
        else if (strobe.savedSel[k])
          savedWord[k] <= merged;
        else if (strobe.directSel[k])
          savedWord[k] <= savedWrData;
      end
    end
  endgenerate

  always_comb begin
    rdSel       = bankOf(savedRdMode);
    savedRdData = liveWord;
    for (int i = 0; i < SAVED_BANKS; i++)
      if (rdSel[i]) savedRdData = savedWord[i];
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        msrValid,
  input  logic        msrToSaved,
  input  logic [3:0]  msrMask,
  input  logic [31:0] msrData,
  input  logic        savedWrValid,
  input  logic [4:0]  savedWrMode,
  input  logic [31:0] savedWrData,
  input  logic [4:0]  savedRdMode,
  output logic [31:0] savedRdData,
  output logic [31:0] statusWord,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagC,
  output logic        flagV,
  output logic        irqMasked,
  output logic        fiqMasked,
  output logic [4:0]  modeField,
  output logic        modeChange
);
  psrStrobe_t strobe;

  psr_ctrl u_ctrl (
    .msrValid    (msrValid),
    .msrToSaved  (msrToSaved),
    .msrMask     (msrMask),
    .savedWrValid(savedWrValid),
    .savedWrMode (savedWrMode),
    .curMode     (statusWord[MODE_W-1:0]),
    .strobe      (strobe)
  );

  psr_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .msrData    (msrData),
    .savedWrData(savedWrData),
    .savedRdMode(savedRdMode),
    .liveWord   (statusWord),
    .savedRdData(savedRdData),
    .modeChange (modeChange)
  );

  assign flagN     = statusWord[31];
  assign flagZ     = statusWord[30];
  assign flagC     = statusWord[29];
  assign flagV     = statusWord[28];
  assign irqMasked = statusWord[7];
  assign fiqMasked = statusWord[6];
  assign modeField = statusWord[4:0];

  // R3: user mode keeps the lower three bytes across a live request
  assert_user_low_bytes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (msrValid && !msrToSaved && modeField == MODE_USER) |=> $stable(statusWord[23:0]));

  // R6: a saved-target request never alters the live word
  assert_saved_keeps_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    (msrValid && msrToSaved) |=> $stable(statusWord));

  // R5: strobe only follows a real mode change
  assert_strobe_on_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |-> (modeField != $past(modeField)));

  // R5: no strobe means the mode held
  assert_no_strobe_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!modeChange && $past(rstN)) |-> $stable(modeField));

  // R2: no request leaves the live word untouched
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    !msrValid |=> $stable(statusWord));

  // R8: modes without a saved word read the live word
  assert_unbanked_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bankOf(savedRdMode) == '0) |-> (savedRdData == statusWord));
endmodule

// File: tb/tb_psr_unit.sv
module tb_psr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msrValid = 1'b0, msrToSaved = 1'b0;
  logic [3:0]  msrMask = '0;
  logic [31:0] msrData = '0;
  logic        savedWrValid = 1'b0;
  logic [4:0]  savedWrMode = '0;
  logic [31:0] savedWrData = '0;
  logic [4:0]  savedRdMode = '0;
  logic [31:0] savedRdData, statusWord;
  logic        flagN, flagZ, flagC, flagV, irqMasked, fiqMasked, modeChange;
  logic [4:0]  modeField;

  always #2 clk = ~clk;

  psr_unit dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit started = 0;
  logic [31:0] mLive;
  logic [31:0] mSaved [5];
  bit          mChg;

  function automatic int idxOf(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [4:0] pickMode(input int s);
    case (s % 8)
      0: return 5'b10000; 1: return 5'b10001; 2: return 5'b10010;
      3: return 5'b10011; 4: return 5'b10111; 5: return 5'b11011;
      6: return 5'b11111; default: return 5'b00101;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated at each edge
  always @(posedge clk) begin
    logic [31:0] nl, ns;
    int cb, db;
    started = 1;
    cycles++;
    if (!rstN) begin
      mLive = 32'h0000_00D3;
      for (int i = 0; i < 5; i++) mSaved[i] = '0;
      mChg = 0;
    end else begin
      nl = mLive;
      cb = idxOf(mLive[4:0]);
      db = idxOf(savedWrMode);
      if (msrValid && !msrToSaved)
        for (int b = 0; b < 4; b++)
          if (msrMask[b] && (b == 3 || mLive[4:0] != 5'b10000))
            nl[b*8 +: 8] = msrData[b*8 +: 8];
      if (savedWrValid && db >= 0 && !(msrValid && msrToSaved && cb == db))
        mSaved[db] = savedWrData;
      if (msrValid && msrToSaved && cb >= 0) begin
        ns = mSaved[cb];
        for (int b = 0; b < 4; b++)
          if (msrMask[b]) ns[b*8 +: 8] = msrData[b*8 +: 8];
        mSaved[cb] = ns;
      end
      mChg = (nl[4:0] != mLive[4:0]);
      mLive = nl;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    int ri;
    if (started) begin
      chk("R1 R2 R3 status", statusWord, mLive);
      chk("R4 fields", {flagN, flagZ, flagC, flagV, irqMasked, fiqMasked, modeField},
          {mLive[31:28], mLive[7], mLive[6], mLive[4:0]});
      chk("R5 strobe", {31'd0, modeChange}, {31'd0, mChg});
      ri = idxOf(savedRdMode);
      chk("R6 R7 R8 R9 R10 saved", savedRdData, (ri >= 0) ? mSaved[ri] : mLive);
    end
  end

  task automatic step(input bit mv, input bit ts, input logic [3:0] mk, input logic [31:0] md,
                      input bit wv, input logic [4:0] wm, input logic [31:0] wd,
                      input logic [4:0] rm);
    @(posedge clk); #1;
    msrValid = mv; msrToSaved = ts; msrMask = mk; msrData = md;
    savedWrValid = wv; savedWrMode = wm; savedWrData = wd; savedRdMode = rm;
  endtask

  task automatic idle(input logic [4:0] rm);
    step(0, 0, 4'h0, 32'h0, 0, 5'h0, 32'h0, rm);
  endtask

  initial begin
    fork
      begin : watchdog
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset word", statusWord, 32'h0000_00D3);
    rstN = 1'b1;
    idle(5'b10011);
    // R6: saved-target request in supervisor mode
    step(1, 1, 4'b1001, 32'hA1B2C3D4, 0, 5'h0, 32'h0, 5'b10011);
    // R9: direct write to interrupt bank and to user (dropped)
    step(0, 0, 4'h0, 32'h0, 1, 5'b10010, 32'h12345678, 5'b10010);
    step(0, 0, 4'h0, 32'h0, 1, 5'b10000, 32'hDEADBEEF, 5'b10000);
    // R10: same-bank collision, then different-bank
    step(1, 1, 4'b0010, 32'h0000_5500, 1, 5'b10011, 32'hFFFF_FFFF, 5'b10011);
    step(1, 1, 4'b0100, 32'h0066_0000, 1, 5'b10111, 32'h0BAD_F00D, 5'b10111);
    idle(5'b10011);
    // R2: byte masks on the live word, no mode change
    step(1, 0, 4'b1000, 32'hF000_0000, 0, 5'h0, 32'h0, 5'b10011);
    step(1, 0, 4'b0110, 32'h00AB_CD00, 0, 5'h0, 32'h0, 5'b10011);
    // R5: move to interrupt mode, then user mode
    step(1, 0, 4'b0001, 32'h0000_0092, 0, 5'h0, 32'h0, 5'b10010);
    idle(5'b10010);
    step(1, 0, 4'b0001, 32'h0000_0010, 0, 5'h0, 32'h0, 5'b10000);
    idle(5'b10000);
    // R3: user mode ignores low enables; R7 saved request has no effect
    step(1, 0, 4'b1111, 32'h5A00_0013, 0, 5'h0, 32'h0, 5'b10011);
    step(1, 1, 4'b1111, 32'h7777_7777, 0, 5'h0, 32'h0, 5'b10011);
    idle(5'b10010);
    idle(5'b10111);
    // reset again, then mixed traffic
    @(posedge clk); #1; rstN = 1'b0;
    idle(5'b10011);
    @(posedge clk); #1; rstN = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom % 4 != 0) d[4:0] = pickMode($urandom);
      if (n % 300 == 299) begin
        @(posedge clk); #1; rstN = 1'b0;
        @(posedge clk); #1; rstN = 1'b1;
      end
      step($urandom % 2, $urandom % 3 == 0, 4'($urandom), d,
           $urandom % 3 == 0, pickMode($urandom), $urandom, pickMode($urandom));
    end
    idle(5'b10001);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule